// File: doc/BRIEF.md
# I2C Two-Register Target

This block is an I2C target that lets a bus master reach two 8-bit registers. The first is a control/status register whose bit 1 is a write-enable latch. The second is a sequencing register. The block samples SCL and SDA through two-flop synchronizers. It detects start, repeated start and stop as SDA edges while SCL is high. SDA is driven as an open-drain pull-down enable.

A master writes with this sequence: start, device address with R/W = 0, word address, one data byte, stop. A master reads one register by first doing a dummy write that sets the word address. It then issues a repeated start and the device address with R/W = 1, takes the returned byte MSB first, answers with a NACK, and sends a stop. Only word address 0x00 (control/status) and 0xFF (sequencing) exist. The latch blocks every write except a write to the latch bit itself. Both register values are also presented as outputs for the surrounding logic.

Top module: `i2c_regbus_target`

## Requirements
- R1: After reset, sda_oe_o is 0, stat_o is 0x00 (latch clear) and seq_o is 0x00.
- R2: An address byte is acknowledged (SDA pulled low in the ninth clock) only when its upper seven bits, MSB first, equal 1010 followed by strap_i[2:0]. Its last bit selects write (0) or read (1).
- R3: After an address byte that does not match, the target never pulls SDA low and no register changes until the next start condition.
- R4: Word address 0x00 selects stat_o and 0xFF selects seq_o, and both are acknowledged. Any other word address is not acknowledged, and the data that follows is not acknowledged and not stored.
- R5: A write to word address 0x00 always loads data bit 1 into the latch bit, stat_o[1].
- R6: While stat_o[1] is 0 before a write, that write leaves seq_o and stat_o bits other than bit 1 unchanged.
- R7: While stat_o[1] is 1 before a write, a single-byte write loads the whole byte into the addressed register.
- R8: A dummy write of the word address, then a repeated start and a read address, makes the target send the addressed register MSB first, one bit per SCL clock.
- R9: A stop condition, including one issued during the ninth clock of a read, releases SDA and returns the target to idle, ready for the next start.
- R10: The target changes its SDA drive only while SCL is low.
- R11: A repeated start in the middle of a byte abandons that byte, stores nothing from it, and restarts the address phase.
- R12: Only one data byte is accepted per write. A further byte in the same transfer is neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (resolved wire) |
| strap_i | input | 3 | Strap bits forming the low part of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| stat_o | output | 8 | Control/status register, bit 1 is the write-enable latch |
| seq_o | output | 8 | Sequencing register |

## Verification
The assertions assume a well-behaved master. It moves SDA only while SCL is low, except to make start or stop. It never makes start or stop while the target pulls SDA low. Every SCL phase lasts well beyond the synchronizer latency. The bench master holds each SCL quarter phase for six system clocks and changes SDA only in the middle of the low phase. It resolves the bus as a wired AND of its own drive and the target's pull-down, so the target's acknowledge and data bits appear on the line just as they would on a real bus.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WADR, ST_WACK,
    ST_WDAT, ST_DACK, ST_RDAT, ST_RACK, ST_IGN
  } state_e;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int WEL_BIT = 1;
endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] seq_o
);
  localparam logic [DW-1:0] WEL_MASK = DW'(1) << WEL_BIT;

  logic [DW-1:0] stat_q, seq_q;
  logic wel;

  assign wel = stat_q[WEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      seq_q  <= '0;
    end else if (wr_i) begin
      if (!sel_i)
        stat_q <= wel ? wdata_i : ((stat_q & ~WEL_MASK) | (wdata_i & WEL_MASK));
      else if (wel)
        seq_q <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? seq_q : stat_q;
  assign stat_o  = stat_q;
  assign seq_o   = seq_q;

  // R6
  locked_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wel |=> $stable(seq_q));
  // R6
  locked_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wel |=> (stat_q & ~WEL_MASK) == $past(stat_q & ~WEL_MASK));
  // R5
  wel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !sel_i |=> stat_q[WEL_BIT] == $past(wdata_i[WEL_BIT]));
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int DW      = 8,
  parameter int STRAP_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DW-1:0]      rdata_i,
  output logic               oe_o,
  output logic               wr_o,
  output logic               sel_o,
  output logic [DW-1:0]      wdata_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  state_e         state_q;
  logic [DW-1:0]  shreg_q, txsh_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q, rw_q, ptr_q, oe_q, wr_q;
  logic addr_hit, wa_ok, rx_state;

  assign addr_hit = shreg_q[DW-1:1] == {TYPE_CODE, strap_i};
  assign wa_ok    = (shreg_q == '0) || (shreg_q == '1);
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_WADR) || (state_q == ST_WDAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      txsh_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      ptr_q   <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        done_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else if (rx_state) begin
        if (rise_i) begin
          shreg_q <= {shreg_q[DW-2:0], sda_i};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST) done_q <= 1'b1;
        end else if (fall_i && done_q) begin
          done_q <= 1'b0;
          cnt_q  <= '0;
          if (state_q == ST_ADDR) begin
            if (addr_hit) begin
              oe_q    <= 1'b1;
              rw_q    <= shreg_q[0];
              state_q <= ST_AACK;
            end else begin
              state_q <= ST_IGN;
            end
          end else if (state_q == ST_WADR) begin
            if (wa_ok) begin
              ptr_q   <= shreg_q[DW-1];
              oe_q    <= 1'b1;
              state_q <= ST_WACK;
            end else begin
              state_q <= ST_IGN;
            end
          end else begin
            wr_q    <= 1'b1;
            oe_q    <= 1'b1;
            state_q <= ST_DACK;
          end
        end
      end else begin
        case (state_q)
          ST_AACK: if (fall_i) begin
            if (rw_q) begin
              txsh_q  <= rdata_i;
              oe_q    <= ~rdata_i[DW-1];
              state_q <= ST_RDAT;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADR;
            end
          end
          ST_WACK: if (fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDAT;
          end
          ST_DACK: if (fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_IGN;
          end
          ST_RDAT: begin
            if (rise_i) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST) done_q <= 1'b1;
            end else if (fall_i) begin
              if (done_q) begin
                done_q  <= 1'b0;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                txsh_q <= txsh_q << 1;
                oe_q   <= ~txsh_q[DW-2];
              end
            end
          end
          ST_RACK: if (rise_i) state_q <= ST_IGN;
          default: ;
        endcase
      end
    end
  end

  assign oe_o    = oe_q;
  assign wr_o    = wr_q;
  assign sel_o   = ptr_q;
  assign wdata_o = shreg_q;

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE) && !oe_q);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_i && $past(scl_i) |-> $stable(oe_q));
  // R3
  ign_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGN |-> !oe_q);
  // R2
  ack_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_AACK |-> oe_q && (shreg_q[DW-1:1] == {TYPE_CODE, strap_i}));
  // R4
  wa_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WACK |-> (shreg_q == '0) || (shreg_q == '1));
endmodule

// File: rtl/i2c_regbus_target.sv
module i2c_regbus_target #(
  parameter int DW          = 8,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [DW-1:0]      stat_o,
  output logic [DW-1:0]      seq_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  logic wr, sel;
  logic [DW-1:0] wdata, rdata;

  i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  i2ct_fsm #(.DW(DW), .STRAP_W(STRAP_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .strap_i(strap_i), .rdata_i(rdata), .oe_o(sda_oe_o),
    .wr_o(wr), .sel_o(sel), .wdata_o(wdata)
  );

  i2ct_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .stat_o(stat_o), .seq_o(seq_o)
  );
endmodule

// File: tb/i2c_regbus_target_bench.sv
module i2c_regbus_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic oe;
  logic [7:0] stat, seq;
  wire sda_line = sda_m & ~oe;

  int tests = 0;
  int fails = 0;
  int r10_viol = 0;
  logic [7:0] m_stat = 8'h00, m_seq = 8'h00;
  logic m_ptr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regbus_target u_i2c_regbus_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(oe), .stat_o(stat), .seq_o(seq)
  );

  // R10 monitor
  always @(oe) if (rst_n && scl) r10_viol++;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; qw(); scl = 1'b1; qw(); s = sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
  endtask

  function automatic logic wa_ok(input logic [7:0] w);
    return (w == 8'h00) || (w == 8'hFF);
  endfunction

  task automatic model_write(input logic p, input logic [7:0] d);
    if (!p) m_stat = m_stat[1] ? d : {m_stat[7:2], d[1], m_stat[0]};
    else if (m_stat[1]) m_seq = d;
  endtask

  function automatic logic [7:0] model_read();
    return m_ptr ? m_seq : m_stat;
  endfunction

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] wa, input logic [7:0] d, input string tag);
    logic a0, a1, a2;
    logic e0, e1;
    do_start();
    send_byte({a, 1'b0}, a0);
    send_byte(wa, a1);
    send_byte(d, a2);
    do_stop();
    e0 = (a == DEV);
    e1 = e0 && wa_ok(wa);
    if (e1) begin
      m_ptr = wa[7];
      model_write(m_ptr, d);
    end
    check({a0, a1, a2} == {e0, e1, e1}, {tag, " acks"}, {5'd0, a0, a1, a2}, {5'd0, e0, e1, e1});
    check(stat == m_stat, {tag, " stat_o"}, stat, m_stat);
    check(seq == m_seq, {tag, " seq_o"}, seq, m_seq);
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] wa, input string tag);
    logic a0, a1, a2, s;
    logic e0, e1, e2;
    logic [7:0] d, ed;
    do_start();
    send_byte({a, 1'b0}, a0);
    send_byte(wa, a1);
    do_start();
    send_byte({a, 1'b1}, a2);
    recv_byte(d);
    bit_io(1'b1, s);
    do_stop();
    e0 = (a == DEV);
    e1 = e0 && wa_ok(wa);
    e2 = (a == DEV);
    if (e1) m_ptr = wa[7];
    ed = e2 ? model_read() : 8'hFF;
    check({a0, a1, a2} == {e0, e1, e2}, {tag, " acks"}, {5'd0, a0, a1, a2}, {5'd0, e0, e1, e2});
    check(d == ed, {tag, " data"}, d, ed);
    check(oe == 1'b0, {tag, " released after stop"}, {7'd0, oe}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    logic [31:0] r;
    r = $urandom(32'd20240);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(oe == 1'b0, "R1 sda released", {7'd0, oe}, 8'h00);
    check(stat == 8'h00, "R1 stat reset", stat, 8'h00);
    check(seq == 8'h00, "R1 seq reset", seq, 8'h00);

    // R6 locked writes
    wr_txn(DEV, 8'hFF, 8'h5A, "R6 locked seq");
    wr_txn(DEV, 8'h00, 8'hF1, "R6 locked stat");
    // R5 latch set, then R7 writes
    wr_txn(DEV, 8'h00, 8'h02, "R5 set latch");
    wr_txn(DEV, 8'hFF, 8'hA5, "R7 seq write");
    wr_txn(DEV, 8'h00, 8'hC6, "R7 stat write");
    // R8 random reads
    rd_txn(DEV, 8'hFF, "R8 read seq");
    rd_txn(DEV, 8'h00, "R8 read stat");
    // R4 invalid word address
    wr_txn(DEV, 8'h3C, 8'h00, "R4 bad word addr");
    // R3 address mismatch (strap differs, then type differs)
    wr_txn({4'b1010, 3'b100}, 8'hFF, 8'h00, "R3 strap mismatch");
    wr_txn({4'b1011, STRAP}, 8'h00, 8'h00, "R3 type mismatch");
    // R2 strap-sensitive match exercised above; read with wrong address
    rd_txn({4'b1010, 3'b001}, 8'hFF, "R2 read mismatch");

    // R12 extra byte
    do_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFF, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    do_stop();
    m_ptr = 1'b1;
    model_write(1'b1, 8'h11);
    check(a == 1'b0, "R12 extra byte nack", {7'd0, a}, 8'h00);
    check(seq == m_seq, "R12 seq keeps first byte", seq, m_seq);

    // R11 repeated start mid data byte
    do_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFF, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    do_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d);
    bit_io(1'b1, s);
    do_stop();
    check(d == m_seq, "R11 read after restart", d, m_seq);
    check(seq == m_seq, "R11 partial byte not stored", seq, m_seq);

    // R9 stop during ninth clock of a read
    do_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    do_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d);
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
    m_ptr = 1'b0;
    check(d == m_stat, "R9 data before early stop", d, m_stat);
    check(oe == 1'b0, "R9 released", {7'd0, oe}, 8'h00);
    rd_txn(DEV, 8'hFF, "R9 next transfer after early stop");

    // constrained random mix
    for (int n = 0; n < 50; n++) begin
      logic [6:0] ra;
      logic [7:0] rw, rd;
      r = $urandom();
      ra = (r[3:0] < 4'd12) ? DEV : (DEV ^ 7'(r[10:4] | 7'd1));
      rw = (r[13:11] < 3'd3) ? 8'h00 : (r[13:11] < 3'd6) ? 8'hFF : r[21:14];
      rd = 8'($urandom());
      if (r[31]) wr_txn(ra, rw, rd, "R7 random write");
      else rd_txn(ra, rw, "R8 random read");
    end

    check(r10_viol == 0, "R10 drive change while scl high", 8'(r10_viol), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule